// File: doc/BRIEF.md
# Pixel Output Port Formatter

This block places one stream of decoded pixels onto a 16-bit parallel output port. Each clock it takes luma, both co-sited chroma samples and a 5/6/5 RGB triple, together with an active-video flag. It then drives one registered output word laid out for the selected port mode. There are four modes:

- 8-bit multiplexed YCbCr on the upper byte.
- 16-bit YCbCr, with luma in the upper byte and chroma in the lower byte.
- 15-bit RGB.
- 16-bit RGB.

In the multiplexed mode the clock runs at twice the pixel rate. Each clock carries one component, in a fixed order that restarts at the start of every active line. The upstream source holds a pixel's values for the two clocks that carry it.

The mode input is taken only while the active flag is low, so one line never mixes two pin layouts. Outside active video the port and the valid output are driven low.

Top module: `pix_port_fmt`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `out_valid` is 0 and `out_port` is 0.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock. `out_port` carries the word formed from the inputs of that same earlier clock.
- R3: Whenever `out_valid` is 0, `out_port` is 0.
- R4: In mode code 0 (8-bit YCbCr), `out_port[15:8]` carries a component chosen by how many clocks the line has been active. Active clock 0 carries `in_cb`, clock 1 carries `in_y`, clock 2 carries `in_cr` and clock 3 carries `in_y`, repeating every four clocks. The count restarts at 0 on the first active clock of every line.
- R5: In mode code 0, `out_port[7:0]` is 0 on every active word.
- R6: In mode code 1 (16-bit YCbCr), `out_port[15:8]` is `in_y`. `out_port[7:0]` is `in_cb` on even-numbered active clocks of a line and `in_cr` on odd ones, counting from 0 at line start.
- R7: In mode code 2 (15-bit RGB), the layout is:
  - `out_port[4:0]` is `in_blu`.
  - `out_port[9:5]` is `in_grn[4:0]`.
  - `out_port[14:10]` is `in_red`.
  - `out_port[15]` is 0.
  - `in_grn[5]` has no effect.
- R8: In mode code 3 (16-bit RGB), the layout is:
  - `out_port[4:0]` is `in_blu`.
  - `out_port[10:5]` is `in_grn`.
  - `out_port[15:11]` is `in_red`.
- R9: The mode is captured on every clock where `in_valid` is 0. A line uses the mode present on the last blanking clock before it. Changes to `mode_sel` while `in_valid` is 1 have no effect until the next blanking clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock (twice the pixel rate in mode 0) |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Port mode: 0 YCbCr 8-bit, 1 YCbCr 16-bit, 2 RGB 5/5/5, 3 RGB 5/6/5 |
| in_valid | input | 1 | Active-video flag for the current inputs |
| in_y | input | 8 | Luma sample |
| in_cb | input | 8 | Blue-difference chroma sample |
| in_cr | input | 8 | Red-difference chroma sample |
| in_red | input | 5 | Red component |
| in_grn | input | 6 | Green component (bit 5 unused in mode 2) |
| in_blu | input | 5 | Blue component |
| out_valid | output | 1 | Output word is active video |
| out_port | output | 16 | Formatted output port |

## Verification
Lines are driven in each of the four modes. Every component carries a distinct, changing value, so a swapped byte, a misplaced colour field or a wrong chroma choice produces a visibly different word.

Line lengths are chosen to break off the multiplexed sequence part-way. Lines of 6 and 7 clocks are followed by new lines, which shows whether the component order really restarts at Cb or carries on from the previous line.

One line has the mode input changed while the flag is high. This separates a design that captures the mode only in blanking from one that follows the input directly. In 15-bit mode the unused green bit is set, which exposes any leak of that bit onto the port.

// File: rtl/pix_fmt_pkg.sv
package pix_fmt_pkg;
   typedef enum logic [1:0] {
      PM_YC8   = 2'd0,
      PM_YC16  = 2'd1,
      PM_RGB15 = 2'd2,
      PM_RGB16 = 2'd3
   } pix_mode_e;
endpackage

// File: rtl/pix_fmt_seq.sv
module pix_fmt_seq
   import pix_fmt_pkg::*;
#(
   parameter int SLOT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        mode_sel,
   output pix_mode_e         mode_q,
   output logic [SLOT_W-1:0] slot
);
   if (SLOT_W < 2) begin : g_bad_slot
      $error("pix_fmt_seq: SLOT_W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= PM_YC8;
         slot   <= '0;
      end else begin
         if (!in_valid) begin
            mode_q <= pix_mode_e'(mode_sel);
            slot   <= '0;
         end else begin
            slot   <= slot + 1'b1;
         end
      end
   end

   // R9
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && $past(in_valid)) |-> $stable(mode_q));

   // R4
   slot_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_valid) |-> (slot == '0));
endmodule

// File: rtl/pix_fmt_map.sv
module pix_fmt_map
   import pix_fmt_pkg::*;
#(
   parameter int COMP_W = 8,
   parameter int R_W    = 5,
   parameter int G_W    = 6,
   parameter int B_W    = 5,
   parameter int SLOT_W = 2,
   localparam int PORT_W = 2 * COMP_W
) (
   input  pix_mode_e         mode,
   input  logic [SLOT_W-1:0] slot,
   input  logic [COMP_W-1:0] y,
   input  logic [COMP_W-1:0] cb,
   input  logic [COMP_W-1:0] cr,
   input  logic [R_W-1:0]    r,
   input  logic [G_W-1:0]    g,
   input  logic [B_W-1:0]    b,
   output logic [PORT_W-1:0] word
);
   localparam int G15_W  = G_W - 1;
   localparam int R15_LO = B_W + G15_W;
   localparam int R16_LO = B_W + G_W;

   if (R_W + G_W + B_W != PORT_W) begin : g_bad_rgb
      $error("pix_fmt_map: RGB widths must fill the port");
   end
   if (R15_LO + R_W != PORT_W - 1) begin : g_bad_rgb15
      $error("pix_fmt_map: 15-bit layout must leave one spare bit");
   end

   logic [COMP_W-1:0] mux_byte;
   logic [COMP_W-1:0] chroma;

   always_comb begin
      unique case (slot[1:0])
         2'd0:    mux_byte = cb;
         2'd2:    mux_byte = cr;
         default: mux_byte = y;
      endcase
      chroma = slot[0] ? cr : cb;
   end

   always_comb begin
      word = '0;
      unique case (mode)
         PM_YC8:  word = {mux_byte, {COMP_W{1'b0}}};
         PM_YC16: word = {y, chroma};
         PM_RGB15: begin
            word[B_W-1:0]         = b;
            word[B_W +: G15_W]    = g[G15_W-1:0];
            word[R15_LO +: R_W]   = r;
         end
         PM_RGB16: begin
            word[B_W-1:0]         = b;
            word[B_W +: G_W]      = g;
            word[R16_LO +: R_W]   = r;
         end
         default: word = '0;
      endcase
   end
endmodule

// File: rtl/pix_port_fmt.sv
module pix_port_fmt
   import pix_fmt_pkg::*;
#(
   parameter int COMP_W  = 8,
   parameter int R_W     = 5,
   parameter int G_W     = 6,
   parameter int B_W     = 5,
   parameter bit OUT_REG = 1'b1,
   localparam int PORT_W = 2 * COMP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_sel,
   input  logic              in_valid,
   input  logic [COMP_W-1:0] in_y,
   input  logic [COMP_W-1:0] in_cb,
   input  logic [COMP_W-1:0] in_cr,
   input  logic [R_W-1:0]    in_red,
   input  logic [G_W-1:0]    in_grn,
   input  logic [B_W-1:0]    in_blu,
   output logic              out_valid,
   output logic [PORT_W-1:0] out_port
);
   localparam int SLOT_W = 2;

   if (COMP_W < 1) begin : g_bad_comp
      $error("pix_port_fmt: COMP_W must be positive");
   end

   pix_mode_e         mode_q;
   logic [SLOT_W-1:0] slot;
   logic [PORT_W-1:0] word;

   pix_fmt_seq #(.SLOT_W(SLOT_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .mode_sel (mode_sel),
      .mode_q   (mode_q),
      .slot     (slot)
   );

   pix_fmt_map #(
      .COMP_W (COMP_W),
      .R_W    (R_W),
      .G_W    (G_W),
      .B_W    (B_W),
      .SLOT_W (SLOT_W)
   ) u_map (
      .mode (mode_q),
      .slot (slot),
      .y    (in_y),
      .cb   (in_cb),
      .cr   (in_cr),
      .r    (in_red),
      .g    (in_grn),
      .b    (in_blu),
      .word (word)
   );

   if (OUT_REG) begin : g_reg
      logic              vld_q;
      logic [PORT_W-1:0] port_q;
      pix_mode_e         mode_d;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q  <= 1'b0;
            port_q <= '0;
            mode_d <= PM_YC8;
         end else begin
            vld_q  <= in_valid;
            port_q <= in_valid ? word : '0;
            mode_d <= mode_q;
         end
      end

      assign out_valid = vld_q;
      assign out_port  = port_q;

      // R2
      valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (out_valid == $past(in_valid)));

      // R5
      yc8_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && mode_d == PM_YC8) |-> (out_port[COMP_W-1:0] == '0));

      // R7
      rgb15_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && mode_d == PM_RGB15) |-> (out_port[PORT_W-1] == 1'b0));
   end else begin : g_comb
      assign out_valid = in_valid;
      assign out_port  = in_valid ? word : '0;
   end

   // R3
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_port == '0));
endmodule

// File: tb/sim_pix_port_fmt.sv
module sim_pix_port_fmt;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode_sel = 2'd0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_y = '0, in_cb = '0, in_cr = '0;
   logic [4:0]  in_red = '0, in_blu = '0;
   logic [5:0]  in_grn = '0;
   logic        out_valid;
   logic [15:0] out_port;

   always #5 clk = ~clk;

   pix_port_fmt u0 (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .in_valid(in_valid),
      .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
      .in_red(in_red), .in_grn(in_grn), .in_blu(in_blu),
      .out_valid(out_valid), .out_port(out_port)
   );

   typedef struct {
      logic        v;
      logic [15:0] d;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;
   logic [1:0] bmode = 2'd0;
   int   bslot = 0;

   task automatic drive(input logic v, input logic [1:0] m, input logic [7:0] y,
                        input logic [7:0] cb, input logic [7:0] cr, input logic [4:0] r,
                        input logic [5:0] g, input logic [4:0] b, input string tag);
      exp_t e;
      in_valid = v; mode_sel = m; in_y = y; in_cb = cb; in_cr = cr;
      in_red = r; in_grn = g; in_blu = b;
      e.v = v; e.d = '0; e.tag = tag;
      if (!v) begin
         bmode = m;
         bslot = 0;
         e.tag = "R3";
      end else begin
         case (bmode)
            2'd0: e.d = {((bslot % 4) == 0) ? cb : ((bslot % 4) == 2) ? cr : y, 8'h00};
            2'd1: e.d = {y, (bslot % 2 == 0) ? cb : cr};
            2'd2: e.d = {1'b0, r, g[4:0], b};
            default: e.d = {r, g, b};
         endcase
         bslot++;
      end
      exp_q.push_back(e);
      @(negedge clk);
   endtask

   task automatic run_line(input logic [1:0] m, input int n, input int seed, input string tag);
      drive(1'b0, m, 8'h00, 8'h00, 8'h00, 5'd0, 6'd0, 5'd0, "R3");
      for (int i = 0; i < n; i++)
         drive(1'b1, m, 8'(seed + i * 7), 8'(8'h40 + i + seed), 8'(8'hC0 - i - seed),
               5'((seed + i) & 31), 6'(((seed * 3 + i) & 63) | 32), 5'((i * 5 + seed) & 31), tag);
   endtask

   always @(posedge clk) begin
      #1;
      if (rst_n && exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         checks++;
         if (out_valid !== e.v) begin
            errors++;
            $display("FAIL R2 %s: out_valid=%b expected %b", e.tag, out_valid, e.v);
         end else if (out_port !== e.d) begin
            errors++;
            $display("FAIL %s: out_port=%h expected %h", e.tag, out_port, e.d);
         end
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      in_valid = 1'b1;
      in_y = 8'hFF;
      repeat (3) @(negedge clk);
      // R1: outputs held low in reset even with active inputs
      checks++;
      if (out_valid !== 1'b0 || out_port !== 16'h0) begin
         errors++;
         $display("FAIL R1: valid=%b port=%h expected 0 0000", out_valid, out_port);
      end
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || out_port !== 16'h0) begin
         errors++;
         $display("FAIL R1: after reset valid=%b port=%h expected 0 0000", out_valid, out_port);
      end
      // R4 R5: odd lengths break the sequence mid-way, then restart
      run_line(2'd0, 7, 3, "R4 R5");
      run_line(2'd0, 6, 17, "R4 R5");
      run_line(2'd0, 9, 40, "R4 R5");
      // R6
      run_line(2'd1, 5, 9, "R6");
      run_line(2'd1, 8, 60, "R6");
      // R7: green bit 5 set by run_line and must not appear
      run_line(2'd2, 6, 11, "R7");
      run_line(2'd2, 4, 29, "R7");
      // R8
      run_line(2'd3, 6, 21, "R8");
      run_line(2'd3, 5, 5, "R8");
      // R9: mode input changes during the line and must be ignored
      drive(1'b0, 2'd1, 8'h00, 8'h00, 8'h00, 5'd0, 6'd0, 5'd0, "R3");
      for (int i = 0; i < 6; i++)
         drive(1'b1, 2'd3, 8'(8'h10 + i), 8'(8'h80 + i), 8'(8'hE0 + i),
               5'(i), 6'(i + 9), 5'(31 - i), "R9");
      // R9: the next blanking clock picks up the new mode
      run_line(2'd3, 4, 33, "R9");
      // R2 R3: blanking gap then one final line
      for (int i = 0; i < 3; i++)
         drive(1'b0, 2'd0, 8'hAA, 8'h55, 8'h33, 5'd7, 6'd7, 5'd7, "R3");
      run_line(2'd0, 3, 77, "R4 R5");
      for (int i = 0; i < 3; i++)
         drive(1'b0, 2'd0, 8'h00, 8'h00, 8'h00, 5'd0, 6'd0, 5'd0, "R3");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule